// File: doc/BRIEF.md
# A/D Conversion Mode Sequencer

This block sequences the conversions of a multi-channel analog-to-digital converter. Software programs it with a single control write that carries a two-bit mode, a channel number, a start bit and a wait-for-read bit. The sequencer then sends a one-cycle start strobe and a channel select to the converter. The converter answers with a done pulse and a data word. The sequencer stores each finished conversion in a result register tagged with its channel. It also raises a one-cycle completion event, and a one-cycle overrun event when a new result replaces one that was never read.

Four modes are offered. Fixed single converts one channel once. Fixed continuous repeats one channel. Scan single walks from the programmed channel down to channel 0 once. Scan continuous repeats that downward walk. Control writes land in the register at once, but they act on conversion only at defined boundaries. The mode is re-evaluated after every conversion. A new channel or start request is picked up after the current conversion in the fixed modes, and only after channel 0 closes the sequence in the scan modes. A write that changes the mode without setting start never starts the converter from idle.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While idle, a control write with start = 1 raises `conv_go` for exactly one cycle, in the cycle after the write, with `conv_chan` equal to the written channel, and `busy` rises in that same cycle.
- R2: While idle, a control write with start = 0 starts nothing, whatever the mode (00, 01, 10 or 11). `conv_go` stays low and `busy` stays low.
- R3: Mode 10 (scan single) started on channel n converts n, n-1, …, 0 in that order and then drops `busy`. If a result is overwritten while still unread, `ovr_evt` pulses.
- R4: Mode 00 (fixed single) performs one conversion on the written channel. `busy` falls only in the cycle the final result is stored.
- R5: Mode 01 (fixed continuous) repeats its channel while start stays set. Mode 11 (scan continuous) repeats the walk n…0. Clearing start ends fixed continuous after the current conversion and scan continuous after channel 0.
- R6: A mode write made during a conversion takes effect only after that conversion. Changing from fixed on channel n to a scan mode continues with n-1 down to 0 and ignores the newly written channel.
- R7: A channel number and start written during a fixed-mode conversion take effect on the next conversion. During a scan they take effect only after channel 0, and a start written mid-scan then begins a new walk from the new channel.
- R8: Every stored result pulses `done_evt` for one cycle. In that same cycle `res_data` and `res_chan` show the new data and the channel it was converted on.
- R9: Storing a result while the previous one is unread pulses `ovr_evt` together with `done_evt`. A one-cycle `res_rd` marks the result as read.
- R10: With wait-for-read set, a finished conversion whose predecessor is unread is parked rather than stored. No further `conv_go` is issued until `res_rd`. The read then stores the parked result without an overrun, and the sequence resumes.
- R11: At most one conversion is outstanding. `conv_go` is never high two cycles in a row, and it is only high while `busy` is high.
- R12: After reset, `busy`, `conv_go`, `done_evt` and `ovr_evt` are low, and `res_data` and `res_chan` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Control write strobe |
| cfg_mode | input | 2 | Mode: 00 fixed single, 01 fixed continuous, 10 scan single, 11 scan continuous |
| cfg_chan | input | CH_W | Channel number to program |
| cfg_start | input | 1 | Start / keep-running bit |
| cfg_wait_rd | input | 1 | Wait-for-read enable |
| conv_go | output | 1 | One-cycle conversion start strobe |
| conv_chan | output | CH_W | Channel for the conversion in flight |
| conv_done | input | 1 | Converter finished pulse |
| conv_data | input | DW | Converter result word |
| res_rd | input | 1 | Result register read strobe |
| busy | output | 1 | Sequence in progress |
| res_data | output | DW | Last stored result |
| res_chan | output | CH_W | Channel tag of the stored result |
| done_evt | output | 1 | One-cycle completion event |
| ovr_evt | output | 1 | One-cycle overrun event |

## Verification
The fixed modes are run with writes that change channel or clear start right after a strobe. This separates an update applied after the current conversion from one applied immediately or never. The scan modes are started on several channels and interrupted by mode, channel and start writes. Comparing the logged strobe channels against the expected downward order shows whether a write was deferred to channel 0 or leaked into the walk. Idle writes without start in every mode test that no conversion is launched. A wait-for-read run with no reads for many cycles shows the difference between parking, overwriting and stalling.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  // mode code: bit 1 selects scan, bit 0 selects repetition
  typedef enum logic [1:0] {
    MD_FIX_ONE  = 2'b00,
    MD_FIX_RUN  = 2'b01,
    MD_SCAN_ONE = 2'b10,
    MD_SCAN_RUN = 2'b11
  } adc_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_CONV = 2'b01,
    ST_HOLD = 2'b10
  } seq_state_e;
endpackage

// File: rtl/adc_seq_cfg.sv
module adc_seq_cfg
  import adc_seq_pkg::*;
#(
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_mode,
  input  logic [CH_W-1:0] cfg_chan,
  input  logic            cfg_start,
  input  logic            cfg_wait_rd,
  input  logic            busy,
  input  logic            req_take,
  output adc_mode_e       mode_q,
  output logic [CH_W-1:0] chan_q,
  output logic            start_q,
  output logic            wrd_q,
  output logic            req_q
);
  adc_mode_e       mode_d;
  logic [CH_W-1:0] chan_d;
  logic            start_d, wrd_d, req_d;

  always_comb begin
    mode_d  = mode_q;
    chan_d  = chan_q;
    start_d = start_q;
    wrd_d   = wrd_q;
    req_d   = req_q;
    if (req_take) req_d = 1'b0;
    if (cfg_we) begin
      mode_d  = adc_mode_e'(cfg_mode);
      chan_d  = cfg_chan;
      start_d = cfg_start;
      wrd_d   = cfg_wait_rd;
      if (!cfg_start)  req_d = 1'b0;
      else if (busy)   req_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MD_FIX_ONE;
      chan_q  <= '0;
      start_q <= 1'b0;
      wrd_q   <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      if (cfg_we) begin
        mode_q  <= mode_d;
        chan_q  <= chan_d;
        start_q <= start_d;
        wrd_q   <= wrd_d;
      end
      req_q <= req_d;
    end
  end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [CH_W-1:0] cfg_chan_in,
  input  logic            cfg_start_in,
  input  adc_mode_e       mode_q,
  input  logic [CH_W-1:0] chan_q,
  input  logic            start_q,
  input  logic            req_q,
  input  logic            conv_done,
  input  logic            res_rd,
  input  logic            hold_need,
  output logic            conv_go,
  output logic [CH_W-1:0] conv_chan,
  output logic            busy,
  output logic            in_conv,
  output logic            in_hold,
  output logic            req_take
);
  seq_state_e      st_q, st_d;
  logic [CH_W-1:0] cur_q, cur_d;
  logic            go_d, commit, scan_more, rerun;

  always_comb begin
    in_conv   = (st_q == ST_CONV);
    in_hold   = (st_q == ST_HOLD);
    commit    = (in_conv && conv_done && !hold_need) || (in_hold && res_rd);
    scan_more = mode_q[1] && (cur_q != '0);
    rerun     = req_q || (mode_q[0] && start_q);
    st_d      = st_q;
    cur_d     = cur_q;
    go_d      = 1'b0;
    req_take  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (cfg_we && cfg_start_in) begin
          st_d  = ST_CONV;
          cur_d = cfg_chan_in;
          go_d  = 1'b1;
        end else if (req_q) begin
          st_d     = ST_CONV;
          cur_d    = chan_q;
          go_d     = 1'b1;
          req_take = 1'b1;
        end
      end
      ST_CONV: if (conv_done && hold_need) st_d = ST_HOLD;
      default: ;
    endcase
    // boundary decision: mode re-read after every conversion
    if (commit) begin
      if (scan_more) begin
        st_d  = ST_CONV;
        cur_d = cur_q - 1'b1;
        go_d  = 1'b1;
      end else if (rerun) begin
        st_d     = ST_CONV;
        cur_d    = chan_q;
        go_d     = 1'b1;
        req_take = 1'b1;
      end else begin
        st_d = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cur_q   <= '0;
      conv_go <= 1'b0;
    end else begin
      st_q    <= st_d;
      conv_go <= go_d;
      if (go_d) cur_q <= cur_d;
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign conv_chan = cur_q;
endmodule

// File: rtl/adc_seq_result.sv
module adc_seq_result #(
  parameter int CH_W = 3,
  parameter int DW   = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_conv,
  input  logic            in_hold,
  input  logic            conv_done,
  input  logic [DW-1:0]   conv_data,
  input  logic [CH_W-1:0] cur_chan,
  input  logic            res_rd,
  input  logic            wrd,
  output logic            hold_need,
  output logic [DW-1:0]   res_data,
  output logic [CH_W-1:0] res_chan,
  output logic            done_evt,
  output logic            ovr_evt
);
  logic [DW-1:0]   park_data;
  logic [CH_W-1:0] park_chan;
  logic            unread_q, unread_eff;
  logic            cap_conv, cap_park, park_en, cap_any;
  logic [DW-1:0]   cap_data;
  logic [CH_W-1:0] cap_chan;

  always_comb begin
    unread_eff = unread_q && !res_rd;
    hold_need  = wrd && unread_eff;
    cap_conv   = in_conv && conv_done && !hold_need;
    park_en    = in_conv && conv_done && hold_need;
    cap_park   = in_hold && res_rd;
    cap_any    = cap_conv || cap_park;
    cap_data   = cap_park ? park_data : conv_data;
    cap_chan   = cap_park ? park_chan : cur_chan;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_data  <= '0;
      res_chan  <= '0;
      park_data <= '0;
      park_chan <= '0;
      unread_q  <= 1'b0;
      done_evt  <= 1'b0;
      ovr_evt   <= 1'b0;
    end else begin
      done_evt <= cap_any;
      ovr_evt  <= cap_conv && unread_eff;
      if (cap_any) begin
        res_data <= cap_data;
        res_chan <= cap_chan;
        unread_q <= 1'b1;
      end else if (res_rd) begin
        unread_q <= 1'b0;
      end
      if (park_en) begin
        park_data <= conv_data;
        park_chan <= cur_chan;
      end
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NCH = 8,
  parameter int DW  = 10,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_mode,
  input  logic [CH_W-1:0] cfg_chan,
  input  logic            cfg_start,
  input  logic            cfg_wait_rd,
  output logic            conv_go,
  output logic [CH_W-1:0] conv_chan,
  input  logic            conv_done,
  input  logic [DW-1:0]   conv_data,
  input  logic            res_rd,
  output logic            busy,
  output logic [DW-1:0]   res_data,
  output logic [CH_W-1:0] res_chan,
  output logic            done_evt,
  output logic            ovr_evt
);
  logic [1:0]      rst_sync;
  logic            rst_q;
  adc_mode_e       mode_q;
  logic [CH_W-1:0] chan_q;
  logic            start_q, wait_rd_q, start_req_q, req_take;
  logic            in_conv, in_hold, hold_need;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  adc_seq_cfg #(.CH_W(CH_W)) i_cfg (
    .clk(clk), .rst_n(rst_q),
    .cfg_we(cfg_we), .cfg_mode(cfg_mode), .cfg_chan(cfg_chan),
    .cfg_start(cfg_start), .cfg_wait_rd(cfg_wait_rd),
    .busy(busy), .req_take(req_take),
    .mode_q(mode_q), .chan_q(chan_q), .start_q(start_q),
    .wrd_q(wait_rd_q), .req_q(start_req_q)
  );

  adc_seq_fsm #(.CH_W(CH_W)) i_fsm (
    .clk(clk), .rst_n(rst_q),
    .cfg_we(cfg_we), .cfg_chan_in(cfg_chan), .cfg_start_in(cfg_start),
    .mode_q(mode_q), .chan_q(chan_q), .start_q(start_q), .req_q(start_req_q),
    .conv_done(conv_done), .res_rd(res_rd), .hold_need(hold_need),
    .conv_go(conv_go), .conv_chan(conv_chan), .busy(busy),
    .in_conv(in_conv), .in_hold(in_hold), .req_take(req_take)
  );

  adc_seq_result #(.CH_W(CH_W), .DW(DW)) i_res (
    .clk(clk), .rst_n(rst_q),
    .in_conv(in_conv), .in_hold(in_hold),
    .conv_done(conv_done), .conv_data(conv_data), .cur_chan(conv_chan),
    .res_rd(res_rd), .wrd(wait_rd_q), .hold_need(hold_need),
    .res_data(res_data), .res_chan(res_chan),
    .done_evt(done_evt), .ovr_evt(ovr_evt)
  );
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_we,
  input logic cfg_start,
  input logic conv_go,
  input logic busy,
  input logic done_evt,
  input logic ovr_evt,
  input logic wrd,
  input logic req
);
  assert_idle_no_go_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(cfg_we && cfg_start) && !req) |=> !conv_go);

  assert_go_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    conv_go |=> !conv_go);

  assert_go_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    conv_go |-> busy);

  assert_ovr_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |-> done_evt);

  assert_wait_no_ovr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |-> !$past(wrd));

  assert_busy_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_evt);
endmodule

bind adc_seq_ctrl adc_seq_chk i_adc_seq_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_start(cfg_start),
  .conv_go(conv_go), .busy(busy), .done_evt(done_evt), .ovr_evt(ovr_evt),
  .wrd(wait_rd_q), .req(start_req_q)
);

// File: tb/test_adc_seq_ctrl.sv
`timescale 1ns/1ps
module test_adc_seq_ctrl;
  localparam int NCH  = 8;
  localparam int DW   = 10;
  localparam int CH_W = 3;
  localparam int LAT  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_start = 1'b0, cfg_wait_rd = 1'b0;
  logic [1:0] cfg_mode = 2'b00;
  logic [CH_W-1:0] cfg_chan = '0;
  logic conv_go, conv_done = 1'b0, res_rd = 1'b0, busy, done_evt, ovr_evt;
  logic [CH_W-1:0] conv_chan, res_chan;
  logic [DW-1:0] conv_data = '0, res_data;

  int checks = 0, errors = 0, cyc = 0;
  int go_log[64], ev_log[64];
  int go_n = 0, ev_n = 0, ovr_n = 0, bad_n = 0;
  int cnt = 0, lch = 0;
  bit outstanding = 0;

  always #10 clk = ~clk;

  adc_seq_ctrl #(.NCH(NCH), .DW(DW)) i_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_chan(cfg_chan), .cfg_start(cfg_start), .cfg_wait_rd(cfg_wait_rd),
    .conv_go(conv_go), .conv_chan(conv_chan), .conv_done(conv_done),
    .conv_data(conv_data), .res_rd(res_rd), .busy(busy),
    .res_data(res_data), .res_chan(res_chan),
    .done_evt(done_evt), .ovr_evt(ovr_evt)
  );

  // monitor and fixed-latency converter model, sampled at the falling edge
  always @(negedge clk) begin
    if (done_evt) begin
      if (ev_n < 64) ev_log[ev_n] = int'(res_chan);
      ev_n++;
      if (int'(res_data) != 100 + 3 * int'(res_chan)) bad_n++;
    end
    if (ovr_evt) ovr_n++;
    conv_done = 1'b0;
    if (cnt != 0) begin
      cnt--;
      if (cnt == 0) begin
        conv_done   = 1'b1;
        conv_data   = DW'(100 + 3 * lch);
        outstanding = 0;
      end
    end
    if (conv_go) begin
      if (go_n < 64) go_log[go_n] = int'(conv_chan);
      go_n++;
      if (outstanding) bad_n++;
      outstanding = 1;
      cnt = LAT;
      lch = int'(conv_chan);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] m, int ch, bit st, bit wrd);
    step();
    cfg_we = 1'b1; cfg_mode = m; cfg_chan = CH_W'(ch);
    cfg_start = st; cfg_wait_rd = wrd;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic rd();
    step();
    res_rd = 1'b1;
    step();
    res_rd = 1'b0;
  endtask

  task automatic wait_idle();
    int quiet = 0;
    for (int i = 0; i < 3000 && quiet < 8; i++) begin
      step();
      if (!busy && cnt == 0) quiet++; else quiet = 0;
    end
  endtask

  task automatic wait_go(int k);
    for (int i = 0; i < 3000 && go_n < k; i++) step();
  endtask

  task automatic fresh();
    rd();
    wait_idle();
    go_n = 0; ev_n = 0; ovr_n = 0; bad_n = 0;
  endtask

  task automatic chk_seq(string req, int e[$]);
    chk(go_n == e.size(), req, go_n, e.size());
    for (int i = 0; i < e.size() && i < go_n; i++)
      chk(go_log[i] == e[i], req, go_log[i], e[i]);
    chk(bad_n == 0, req, bad_n, 0);
  endtask

  task automatic t_reset();
    chk(busy == 0, "R12", busy, 0);
    chk(conv_go == 0, "R12", conv_go, 0);
    chk(done_evt == 0 && ovr_evt == 0, "R12", done_evt + ovr_evt, 0);
    chk(res_data == 0 && res_chan == 0, "R12", int'(res_data), 0);
  endtask

  task automatic t_idle_no_start_r2();
    fresh();
    for (int m = 0; m < 4; m++) begin
      wr(2'(m), 5, 0, 0);
      repeat (20) step();
      chk(busy == 0, "R2", busy, 0);
    end
    chk(go_n == 0, "R2", go_n, 0);
    chk(ev_n == 0, "R2", ev_n, 0);
  endtask

  task automatic t_fixed_single_r4();
    fresh();
    wr(2'b00, 3, 1, 0);
    chk(conv_go == 1, "R1", conv_go, 1);
    chk(int'(conv_chan) == 3, "R1", int'(conv_chan), 3);
    chk(busy == 1, "R1", busy, 1);
    step();
    chk(conv_go == 0, "R11", conv_go, 0);
    wait_idle();
    chk_seq("R4", '{3});
    chk(ev_n == 1 && ev_log[0] == 3, "R8", ev_log[0], 3);
    chk(int'(res_data) == 109, "R8", int'(res_data), 109);
  endtask

  task automatic t_scan_single_r3();
    fresh();
    wr(2'b10, 3, 1, 0);
    wait_idle();
    chk_seq("R3", '{3, 2, 1, 0});
    chk(ev_n == 4 && ev_log[3] == 0, "R8", ev_log[3], 0);
    chk(ovr_n == 3, "R9", ovr_n, 3);
  endtask

  task automatic t_wait_read_r10();
    fresh();
    wr(2'b10, 2, 1, 1);
    repeat (30) step();
    chk(go_n == 2, "R10", go_n, 2);
    chk(ev_n == 1, "R10", ev_n, 1);
    chk(busy == 1, "R10", busy, 1);
    rd();
    repeat (30) step();
    chk(go_n == 3, "R10", go_n, 3);
    chk(ev_n == 2 && ev_log[1] == 1, "R10", ev_log[1], 1);
    rd();
    wait_idle();
    chk(ev_n == 3 && ev_log[2] == 0, "R10", ev_log[2], 0);
    chk(ovr_n == 0, "R10", ovr_n, 0);
    chk_seq("R10", '{2, 1, 0});
  endtask

  task automatic t_fixed_cont_r5();
    fresh();
    wr(2'b01, 6, 1, 0);
    wait_go(3);
    wr(2'b01, 6, 0, 0);
    wait_idle();
    chk_seq("R5", '{6, 6, 6});
    fresh();
    wr(2'b11, 2, 1, 0);
    wait_go(4);
    wr(2'b11, 2, 0, 0);
    wait_idle();
    chk_seq("R5", '{2, 1, 0, 2, 1, 0});
  endtask

  task automatic t_mode_change_r6();
    fresh();
    wr(2'b00, 4, 1, 0);
    wait_go(1);
    wr(2'b10, 7, 0, 0);
    wait_idle();
    chk_seq("R6", '{4, 3, 2, 1, 0});
    chk(ev_n == 5 && ev_log[0] == 4, "R6", ev_log[0], 4);
  endtask

  task automatic t_defer_r7();
    fresh();
    wr(2'b01, 1, 1, 0);
    wait_go(1);
    wr(2'b01, 5, 1, 0);
    wait_go(2);
    wr(2'b01, 5, 0, 0);
    wait_idle();
    chk_seq("R7", '{1, 5});
    fresh();
    wr(2'b10, 3, 1, 0);
    wait_go(1);
    wr(2'b10, 6, 1, 0);
    wait_idle();
    chk_seq("R7", '{3, 2, 1, 0, 6, 5, 4, 3, 2, 1, 0});
  endtask

  initial begin
    repeat (4) step();
    t_reset();
    rst_n = 1'b1;
    repeat (4) step();
    t_reset();
    t_idle_no_start_r2();
    t_fixed_single_r4();
    t_scan_single_r3();
    t_wait_read_r10();
    t_fixed_cont_r5();
    t_mode_change_r6();
    t_defer_r7();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule